// File: doc/BRIEF.md
# Sound Generator Register Front End

This block is the byte-wide register interface of a three-voice sound generator. A host bus supplies a 5-bit address, a data byte and separate write and read strobes. Writes are decoded into per-voice oscillator, pulse and envelope settings and into four filter settings. Every decoded field comes out on an output port, where the synthesis engines can use it.

Reads of four status addresses return values that the engines supply on input ports. A read of any other address returns the byte most recently driven on the bus by a write. That held byte has a limited lifetime and falls to zero once the lifetime ends. The length of the lifetime depends on the chip-model select.

With the model select high (newer model), every register write commits one clock after the bus access. With it low (older model), the write commits on the access edge itself. The delayed write has its own address and data registers.

Top module: `sndreg_front`

## Requirements
- R1: Addresses 0x00-0x14 form three voice groups with base addresses 0x00, 0x07 and 0x0E. Within a group, offset 0 is frequency low, 1 is frequency high, 2 is pulse low, 3 is pulse high, 4 is control, 5 is attack/decay and 6 is sustain/release. `voice_freq` and `voice_pw` carry each voice as {high,low} in bits [v*16+15 : v*16]. `voice_ad` and `voice_sr` carry voice v in bits [v*8+7 : v*8].
- R2: The control byte of voice v drives five outputs. Bits 7:4 go to `wave_sel[v*4+3:v*4]`, bit 3 to `test_bit[v]`, bit 2 to `ring_mod[v]`, bit 1 to `sync_en[v]` and bit 0 to `gate[v]`.
- R3: Address 0x15 loads `flt_cut_lo`, 0x16 loads `flt_cut_hi`, 0x17 loads `flt_res_route` and 0x18 loads `flt_mode_vol`.
- R4: A write to an address from 0x19 to 0x1F changes no register output.
- R5: `rdata` loads on a rising edge where `rd_en` is high and holds its value otherwise. Address 0x19 returns `pot_a`, 0x1A returns `pot_b`, 0x1B returns `osc3_in` and 0x1C returns `env3_in`.
- R6: A read of any address other than 0x19-0x1C returns the byte of the most recent write to any address, including ignored addresses.
- R7: Each write reloads a lifetime counter to 0x1D00 on the older model. Each later cycle without a write lowers the counter by one, and the counter stops at zero. The held byte becomes 0 on the edge where the counter goes from 1 to 0. A read sampled L edges after the write still sees the byte, and a read one edge later sees 0.
- R8: On the newer model the reload value is 0xA2000, so the held byte survives well past the older model's lifetime.
- R9: On the older model a write is visible on the register outputs right after its access edge. On the newer model it becomes visible one edge later. Back-to-back newer-model writes each land, in order.
- R10: While reset is low, all register outputs, `rdata` and the held byte are 0.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| model_new | input | 1 | 1 selects the newer model (delayed writes, long lifetime) |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| pot_a | input | 8 | First potentiometer value |
| pot_b | input | 8 | Second potentiometer value |
| osc3_in | input | 8 | Third voice oscillator output |
| env3_in | input | 8 | Third voice envelope level |
| rdata | output | 8 | Registered read data |
| voice_freq | output | 48 | Frequency word, one 16-bit field per voice |
| voice_pw | output | 48 | Pulse width word, one 16-bit field per voice |
| wave_sel | output | 12 | Waveform select, 4 bits per voice |
| test_bit | output | 3 | Test flag per voice |
| ring_mod | output | 3 | Ring modulation flag per voice |
| sync_en | output | 3 | Sync flag per voice |
| gate | output | 3 | Gate flag per voice |
| voice_ad | output | 24 | Attack/decay byte per voice |
| voice_sr | output | 24 | Sustain/release byte per voice |
| flt_cut_lo | output | 8 | Filter cutoff low byte |
| flt_cut_hi | output | 8 | Filter cutoff high byte |
| flt_res_route | output | 8 | Resonance and routing byte |
| flt_mode_vol | output | 8 | Mode and volume byte |

## Verification
The properties take the strobes, address and model select to be known values on every clock edge. They also assume the model select says which lifetime applies to the write it accompanies. The ignored-address property speaks only about cycles in which no delayed write is waiting to commit, because a pending write may legally change a register on that edge. The stimulus changes the model select only while the delayed-write stage is empty and never reads in the same cycle as a write. Under those conditions, every expected value follows directly from the order of the bus accesses.

// File: rtl/sndreg_pkg.sv
package sndreg_pkg;
  localparam int NVOICE   = 3;
  localparam int VREGS    = 7;
  localparam int NREG     = NVOICE * VREGS + 4;
  localparam int AW       = 5;
  localparam int DW       = 8;

  localparam logic [AW-1:0] A_CUT_LO  = 5'h15;
  localparam logic [AW-1:0] A_CUT_HI  = 5'h16;
  localparam logic [AW-1:0] A_RESROUT = 5'h17;
  localparam logic [AW-1:0] A_MODEVOL = 5'h18;
  localparam logic [AW-1:0] A_POT_A   = 5'h19;
  localparam logic [AW-1:0] A_POT_B   = 5'h1a;
  localparam logic [AW-1:0] A_OSC3    = 5'h1b;
  localparam logic [AW-1:0] A_ENV3    = 5'h1c;

  typedef struct packed {
    logic          vld;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/sndreg_bushold.sv
module sndreg_bushold
  import sndreg_pkg::*;
#(
  parameter int               LIFE_W   = 20,
  parameter logic [LIFE_W-1:0] LIFE_OLD = 20'h01d00,
  parameter logic [LIFE_W-1:0] LIFE_NEW = 20'ha2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              model_new,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     held_q,
  output logic [LIFE_W-1:0] life_q
);
  logic [DW-1:0]     held_d;
  logic [LIFE_W-1:0] life_d;

  always_comb begin
    held_d = held_q;
    life_d = life_q;
    if (wr_en) begin
      held_d = wdata;
      life_d = model_new ? LIFE_NEW : LIFE_OLD;
    end else if (life_q != '0) begin
      life_d = life_q - 1'b1;
      if (life_q == LIFE_W'(1)) held_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      life_q <= '0;
    end else begin
      held_q <= held_d;
      life_q <= life_d;
    end
  end
endmodule

// File: rtl/sndreg_wpipe.sv
module sndreg_wpipe
  import sndreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          model_new,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output wr_req_t       direct_req,
  output wr_req_t       delayed_req
);
  logic          pend_vld_d;
  logic          pend_ce;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] pend_data_q;
  logic          pend_vld_q;

  assign pend_ce    = wr_en & model_new;
  assign pend_vld_d = pend_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_vld_q <= pend_vld_d;
      if (pend_ce) begin
        pend_addr_q <= addr;
        pend_data_q <= wdata;
      end
    end
  end

  assign direct_req  = '{vld: wr_en & ~model_new, addr: addr, data: wdata};
  assign delayed_req = '{vld: pend_vld_q, addr: pend_addr_q, data: pend_data_q};
endmodule

// File: rtl/sndreg_regfile.sv
module sndreg_regfile
  import sndreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  wr_req_t          req_lo,
  input  wr_req_t          req_hi,
  output logic [NREG*DW-1:0] regs_flat
);
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
      if (req_lo.vld && req_lo.addr == AW'(i)) regs_d[i] = req_lo.data;
      if (req_hi.vld && req_hi.addr == AW'(i)) regs_d[i] = req_hi.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = regs_q[g];
  end
endmodule

// File: rtl/sndreg_front.sv
module sndreg_front
  import sndreg_pkg::*;
#(
  parameter int               LIFE_W   = 20,
  parameter logic [LIFE_W-1:0] LIFE_OLD = 20'h01d00,
  parameter logic [LIFE_W-1:0] LIFE_NEW = 20'ha2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 model_new,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [DW-1:0]        pot_a,
  input  logic [DW-1:0]        pot_b,
  input  logic [DW-1:0]        osc3_in,
  input  logic [DW-1:0]        env3_in,
  output logic [DW-1:0]        rdata,
  output logic [NVOICE*16-1:0] voice_freq,
  output logic [NVOICE*16-1:0] voice_pw,
  output logic [NVOICE*4-1:0]  wave_sel,
  output logic [NVOICE-1:0]    test_bit,
  output logic [NVOICE-1:0]    ring_mod,
  output logic [NVOICE-1:0]    sync_en,
  output logic [NVOICE-1:0]    gate,
  output logic [NVOICE*DW-1:0] voice_ad,
  output logic [NVOICE*DW-1:0] voice_sr,
  output logic [DW-1:0]        flt_cut_lo,
  output logic [DW-1:0]        flt_cut_hi,
  output logic [DW-1:0]        flt_res_route,
  output logic [DW-1:0]        flt_mode_vol
);
  localparam int FBASE = NVOICE * VREGS;

  wr_req_t             direct_req;
  wr_req_t             delayed_req;
  logic [NREG*DW-1:0]  regs_flat;
  logic [DW-1:0]       held_q;
  logic [LIFE_W-1:0]   life_q;
  logic [DW-1:0]       rdata_d;

  sndreg_wpipe u_wpipe (
    .clk(clk), .rst_n(rst_n), .model_new(model_new), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .direct_req(direct_req), .delayed_req(delayed_req)
  );

  sndreg_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .req_lo(delayed_req), .req_hi(direct_req),
    .regs_flat(regs_flat)
  );

  sndreg_bushold #(.LIFE_W(LIFE_W), .LIFE_OLD(LIFE_OLD), .LIFE_NEW(LIFE_NEW)) u_hold (
    .clk(clk), .rst_n(rst_n), .model_new(model_new), .wr_en(wr_en),
    .wdata(wdata), .held_q(held_q), .life_q(life_q)
  );

  for (genvar v = 0; v < NVOICE; v++) begin : g_voice
    localparam int B = v * VREGS;
    logic [DW-1:0] ctrl;
    assign ctrl = regs_flat[(B+4)*DW +: DW];
    assign voice_freq[v*16 +: 16] = {regs_flat[(B+1)*DW +: DW], regs_flat[B*DW +: DW]};
    assign voice_pw[v*16 +: 16]   = {regs_flat[(B+3)*DW +: DW], regs_flat[(B+2)*DW +: DW]};
    assign wave_sel[v*4 +: 4]     = ctrl[7:4];
    assign test_bit[v]            = ctrl[3];
    assign ring_mod[v]            = ctrl[2];
    assign sync_en[v]             = ctrl[1];
    assign gate[v]                = ctrl[0];
    assign voice_ad[v*DW +: DW]   = regs_flat[(B+5)*DW +: DW];
    assign voice_sr[v*DW +: DW]   = regs_flat[(B+6)*DW +: DW];
  end

  assign flt_cut_lo    = regs_flat[(FBASE+0)*DW +: DW];
  assign flt_cut_hi    = regs_flat[(FBASE+1)*DW +: DW];
  assign flt_res_route = regs_flat[(FBASE+2)*DW +: DW];
  assign flt_mode_vol  = regs_flat[(FBASE+3)*DW +: DW];

  always_comb begin
    unique case (addr)
      A_POT_A: rdata_d = pot_a;
      A_POT_B: rdata_d = pot_b;
      A_OSC3:  rdata_d = osc3_in;
      A_ENV3:  rdata_d = env3_in;
      default: rdata_d = held_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end
endmodule

// File: rtl/sndreg_front_chk.sv
module sndreg_front_chk
  import sndreg_pkg::*;
#(
  parameter int               LIFE_W   = 20,
  parameter logic [LIFE_W-1:0] LIFE_OLD = 20'h01d00,
  parameter logic [LIFE_W-1:0] LIFE_NEW = 20'ha2000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               model_new,
  input logic               wr_en,
  input logic               rd_en,
  input logic [AW-1:0]      addr,
  input logic [DW-1:0]      pot_a,
  input logic [DW-1:0]      rdata,
  input logic [DW-1:0]      held,
  input logic [LIFE_W-1:0]  life,
  input logic               pend_vld,
  input logic [NREG*DW-1:0] regs_flat
);
  p_held_needs_life_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held != '0) |-> (life != '0));

  p_life_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (life == ($past(model_new) ? LIFE_NEW : LIFE_OLD)));

  p_life_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && life != '0) |=> (life == $past(life) - 1'b1));

  p_ignored_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > A_MODEVOL && !pend_vld) |=> $stable(regs_flat));

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_pot_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_POT_A) |=> (rdata == $past(pot_a)));
endmodule

bind sndreg_front sndreg_front_chk #(
  .LIFE_W(LIFE_W), .LIFE_OLD(LIFE_OLD), .LIFE_NEW(LIFE_NEW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .model_new(model_new), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .pot_a(pot_a), .rdata(rdata), .held(held_q), .life(life_q),
  .pend_vld(delayed_req.vld), .regs_flat(regs_flat)
);

// File: tb/sndreg_front_test.sv
module sndreg_front_test;
  localparam int LIFE_OLD = 'h1d00;

  logic clk = 1'b0;
  logic rst_n, model_new, wr_en, rd_en;
  logic [4:0] addr;
  logic [7:0] wdata, pot_a, pot_b, osc3_in, env3_in, rdata;
  logic [47:0] voice_freq, voice_pw;
  logic [11:0] wave_sel;
  logic [2:0] test_bit, ring_mod, sync_en, gate;
  logic [23:0] voice_ad, voice_sr;
  logic [7:0] flt_cut_lo, flt_cut_hi, flt_res_route, flt_mode_vol;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [7:0] sh [25];

  always #5 clk = ~clk;

  sndreg_front uut (
    .clk(clk), .rst_n(rst_n), .model_new(model_new), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .pot_a(pot_a), .pot_b(pot_b), .osc3_in(osc3_in),
    .env3_in(env3_in), .rdata(rdata), .voice_freq(voice_freq), .voice_pw(voice_pw),
    .wave_sel(wave_sel), .test_bit(test_bit), .ring_mod(ring_mod), .sync_en(sync_en),
    .gate(gate), .voice_ad(voice_ad), .voice_sr(voice_sr), .flt_cut_lo(flt_cut_lo),
    .flt_cut_hi(flt_cut_hi), .flt_res_route(flt_res_route), .flt_mode_vol(flt_mode_vol)
  );

  // {addr, data}: voice (R1), control fields (R2), filter (R3)
  localparam logic [12:0] VEC [12] = '{
    {5'h00, 8'h12}, {5'h01, 8'h34}, {5'h04, 8'h41}, {5'h07, 8'hab},
    {5'h0b, 8'h15}, {5'h0e, 8'h77}, {5'h12, 8'h8a}, {5'h13, 8'hc5},
    {5'h14, 8'h3e}, {5'h15, 8'h07}, {5'h17, 8'hf2}, {5'h18, 8'h1f}
  };

  task automatic chk(input string req, input logic [199:0] act, input logic [199:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [199:0] act_regs();
    return {voice_freq, voice_pw, wave_sel, test_bit, ring_mod, sync_en, gate,
            voice_ad, voice_sr, flt_cut_lo, flt_cut_hi, flt_res_route, flt_mode_vol};
  endfunction

  function automatic logic [199:0] exp_regs();
    logic [47:0] ef, ep;
    logic [11:0] ew;
    logic [2:0] et, er, es, eg;
    logic [23:0] ead, esr;
    for (int v = 0; v < 3; v++) begin
      ef[v*16 +: 16] = {sh[v*7+1], sh[v*7]};
      ep[v*16 +: 16] = {sh[v*7+3], sh[v*7+2]};
      ew[v*4 +: 4]   = sh[v*7+4][7:4];
      et[v] = sh[v*7+4][3];
      er[v] = sh[v*7+4][2];
      es[v] = sh[v*7+4][1];
      eg[v] = sh[v*7+4][0];
      ead[v*8 +: 8] = sh[v*7+5];
      esr[v*8 +: 8] = sh[v*7+6];
    end
    return {ef, ep, ew, et, er, es, eg, ead, esr, sh[21], sh[22], sh[23], sh[24]};
  endfunction

  // Both tasks start and end at a falling edge.
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 5'd25) sh[a] = d;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 25; i++) sh[i] = 8'h00;
    rst_n = 1'b0; model_new = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0; pot_a = 8'h5c; pot_b = 8'ha3; osc3_in = 8'h96; env3_in = 8'h2d;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 regs", act_regs(), exp_regs());
    chk("R10 rdata", {192'd0, rdata}, 200'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h1d, r);
    chk("R10 held", {192'd0, r}, 200'd0);

    // R1 R2 R3 table, older model: visible right after the write edge (R9)
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][12:8], VEC[i][7:0]);
      chk("R1 R2 R3 R9 table", act_regs(), exp_regs());
      rd(5'h1f, r);
      chk("R6 held byte", {192'd0, r}, {192'd0, VEC[i][7:0]});
    end

    // R4: ignored addresses
    wr(5'h19, 8'hc3);
    chk("R4 write 0x19", act_regs(), exp_regs());
    wr(5'h1f, 8'h6e);
    chk("R4 write 0x1f", act_regs(), exp_regs());
    rd(5'h03, r);
    chk("R6 after ignored write", {192'd0, r}, {192'd0, 8'h6e});

    // R5: status reads
    rd(5'h19, r); chk("R5 pot_a", {192'd0, r}, {192'd0, 8'h5c});
    rd(5'h1a, r); chk("R5 pot_b", {192'd0, r}, {192'd0, 8'ha3});
    rd(5'h1b, r); chk("R5 osc3", {192'd0, r}, {192'd0, 8'h96});
    rd(5'h1c, r); chk("R5 env3", {192'd0, r}, {192'd0, 8'h2d});
    pot_a = 8'h01;
    @(negedge clk);
    chk("R5 hold without rd_en", {192'd0, rdata}, {192'd0, 8'h2d});

    // R7: older-model lifetime boundary
    wr(5'h1e, 8'h5a);
    repeat (LIFE_OLD - 1) @(negedge clk);
    rd(5'h1e, r);
    chk("R7 last live cycle", {192'd0, r}, {192'd0, 8'h5a});
    rd(5'h1e, r);
    chk("R7 expired", {192'd0, r}, 200'd0);

    // R9: newer-model delay
    model_new = 1'b1;
    wr(5'h18, 8'hd4);
    sh[24] = 8'h1f;
    chk("R9 not yet visible", act_regs(), exp_regs());
    @(negedge clk);
    sh[24] = 8'hd4;
    chk("R9 one edge later", act_regs(), exp_regs());
    // R9 back-to-back
    addr = 5'h15; wdata = 8'h81; wr_en = 1'b1;
    @(negedge clk);
    addr = 5'h16; wdata = 8'h92;
    @(negedge clk);
    wr_en = 1'b0;
    sh[21] = 8'h81;
    chk("R9 first of pair", act_regs(), exp_regs());
    @(negedge clk);
    sh[22] = 8'h92;
    chk("R9 second of pair", act_regs(), exp_regs());

    // R8: newer-model lifetime outlasts the older one
    wr(5'h1d, 8'hb7);
    repeat (LIFE_OLD + 600) @(negedge clk);
    rd(5'h1d, r);
    chk("R8 long lifetime", {192'd0, r}, {192'd0, 8'hb7});
    model_new = 1'b0;

    // R10: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 25; i++) sh[i] = 8'h00;
    chk("R10 reset again", act_regs(), exp_regs());
    chk("R10 rdata again", {192'd0, rdata}, 200'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h00, r);
    chk("R10 held cleared", {192'd0, r}, 200'd0);

    finish_run();
  end
endmodule